// File: doc/BRIEF.md
# Two-Master Cycle-Locked Bus Arbiter

This block lets two Wishbone masters share a single slave-side bus. It watches the cycle (`cyc`) line of each master. The bus goes to whichever master asserts `cyc` first. That master keeps the bus for as long as its `cyc` stays high, so a multi-beat burst is never split by the other master. A master that requests while the bus is busy waits. It takes over on the first clock edge at which the owner's `cyc` is sampled low, and no idle cycle is inserted between the two owners.

Ownership is held in a small registered state machine with three states: `ARB_IDLE` (no owner), `ARB_M0` (master 0 owns the bus) and `ARB_M1` (master 1 owns the bus). The transitions are:

- IDLE->M0 and IDLE->M1 on a single request.
- IDLE tie-break when both masters request in the same cycle.
- M0->M0 and M1->M1 (hold) while the owner's `cyc` is high.
- M0->M1 and M1->M0 (handover) when the owner's `cyc` is low and the other master is requesting.
- M0->IDLE and M1->IDLE (release) when the owner's `cyc` is low and the other master is not requesting.

A separate register remembers the most recent owner, and the tie-break uses it. The request fields of the owner are steered onto the bus with an AND-OR multiplexer. Acknowledge and read data go back to the owner only.

Top module: `bus_arb2`

## Requirements
- R1: While `rst_i` is high, and after it falls until the first request is sampled, the arbiter has no owner. All bus outputs (`bus_cyc_o`, `bus_stb_o`, `bus_we_o`, `bus_adr_o`, `bus_dat_w_o`, `bus_sel_o`) are 0, and both `mN_ack_o` and `mN_dat_r_o` are 0.
- R2: With no owner, a rising edge at which exactly one master's `cyc` is high makes that master the owner. From then on, its fields appear on the bus.
- R3: With no owner, if both `cyc` lines are high at the same edge, the master that was not the most recent owner wins. After reset, master 1 counts as the most recent owner, so master 0 wins the first tie.
- R4: While the owner's `cyc` is sampled high, ownership does not change, whatever the other master does.
- R5: At an edge where the owner's `cyc` is low and the other master's `cyc` is high, ownership passes directly to the other master.
- R6: At an edge where the owner's `cyc` is low and the other master's `cyc` is also low, the arbiter returns to no owner. All bus outputs are then 0.
- R7: `bus_ack_i` and `bus_dat_r_i` are passed only to the owner. The other master sees ack 0 and read data 0.
- R8: The bus `cyc`, `stb`, `we`, address, write data and byte select always equal the current owner's fields. They are 0 when there is no owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| m0_cyc_i | input | 1 | Master 0 cycle / bus request |
| m0_stb_i | input | 1 | Master 0 strobe |
| m0_we_i | input | 1 | Master 0 write enable |
| m0_adr_i | input | ADDR_W | Master 0 address |
| m0_dat_w_i | input | DATA_W | Master 0 write data |
| m0_sel_i | input | DATA_W/8 | Master 0 byte select |
| m0_ack_o | output | 1 | Master 0 acknowledge |
| m0_dat_r_o | output | DATA_W | Master 0 read data |
| m1_cyc_i | input | 1 | Master 1 cycle / bus request |
| m1_stb_i | input | 1 | Master 1 strobe |
| m1_we_i | input | 1 | Master 1 write enable |
| m1_adr_i | input | ADDR_W | Master 1 address |
| m1_dat_w_i | input | DATA_W | Master 1 write data |
| m1_sel_i | input | DATA_W/8 | Master 1 byte select |
| m1_ack_o | output | 1 | Master 1 acknowledge |
| m1_dat_r_o | output | DATA_W | Master 1 read data |
| bus_cyc_o | output | 1 | Shared bus cycle |
| bus_stb_o | output | 1 | Shared bus strobe |
| bus_we_o | output | 1 | Shared bus write enable |
| bus_adr_o | output | ADDR_W | Shared bus address |
| bus_dat_w_o | output | DATA_W | Shared bus write data |
| bus_sel_o | output | DATA_W/8 | Shared bus byte select |
| bus_ack_i | input | 1 | Slave acknowledge |
| bus_dat_r_i | input | DATA_W | Slave read data |

## Verification
An ownership decision (R2–R6) takes effect one cycle after the edge that samples the `cyc` lines. Forwarding and return routing (R7, R8) are combinational in the current owner, so they are due in the same cycle.

The bench drives every input on the falling edge and compares all outputs 1 ns later, well before the next rising edge. Its reference model updates the expected owner only at the rising edge. In this way the registered decision and the combinational paths are each checked in exactly the cycle they are due.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_MASTERS = 2;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_M0   = 2'd1,
        ARB_M1   = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
    import arb_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] grant_o
);

    arb_state_e state_q, state_d;
    logic       last_m1_q;   // most recent owner was master 1
    logic       last_m1_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= ARB_IDLE;
            last_m1_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            last_m1_q <= last_m1_d;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        last_m1_d = last_m1_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (req_i[0] && req_i[1]) begin
                    state_d = last_m1_q ? ARB_M0 : ARB_M1;
                end else if (req_i[0]) begin
                    state_d = ARB_M0;
                end else if (req_i[1]) begin
                    state_d = ARB_M1;
                end
            end
            ARB_M0: begin
                if (!req_i[0]) begin
                    state_d = req_i[1] ? ARB_M1 : ARB_IDLE;
                end
            end
            ARB_M1: begin
                if (!req_i[1]) begin
                    state_d = req_i[0] ? ARB_M0 : ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
        if (state_d == ARB_M0) last_m1_d = 1'b0;
        if (state_d == ARB_M1) last_m1_d = 1'b1;
    end

    // outputs
    always_comb begin
        grant_o = '0;
        unique case (state_q)
            ARB_IDLE: grant_o = '0;
            ARB_M0:   grant_o = 2'b01;
            ARB_M1:   grant_o = 2'b10;
            default:  grant_o = '0;
        endcase
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(grant_o));

    // R4
    hold_m0_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o[0] && req_i[0]) |=> grant_o[0]);

    // R4
    hold_m1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o[1] && req_i[1]) |=> grant_o[1]);

    // R5
    handover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o[0] && !req_i[0] && req_i[1]) |=> grant_o[1]);

    // R3
    tie_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o == 2'b00 && req_i == 2'b11) |=> $countones(grant_o) == 1);

    // R6
    release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o != 2'b00 && req_i == 2'b00) |=> grant_o == 2'b00);

endmodule

// File: rtl/arb_req_mux.sv
module arb_req_mux
    import arb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int SEL_W = DATA_W / 8
) (
    input  logic [NUM_MASTERS-1:0]             grant_i,
    input  logic [NUM_MASTERS-1:0]             cyc_i,
    input  logic [NUM_MASTERS-1:0]             stb_i,
    input  logic [NUM_MASTERS-1:0]             we_i,
    input  logic [NUM_MASTERS-1:0][ADDR_W-1:0] adr_i,
    input  logic [NUM_MASTERS-1:0][DATA_W-1:0] dat_i,
    input  logic [NUM_MASTERS-1:0][SEL_W-1:0]  sel_i,
    output logic                               cyc_o,
    output logic                               stb_o,
    output logic                               we_o,
    output logic [ADDR_W-1:0]                  adr_o,
    output logic [DATA_W-1:0]                  dat_o,
    output logic [SEL_W-1:0]                   sel_o
);

    always_comb begin
        cyc_o = 1'b0;
        stb_o = 1'b0;
        we_o  = 1'b0;
        adr_o = '0;
        dat_o = '0;
        sel_o = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            cyc_o = cyc_o | (grant_i[i] & cyc_i[i]);
            stb_o = stb_o | (grant_i[i] & stb_i[i]);
            we_o  = we_o  | (grant_i[i] & we_i[i]);
            adr_o = adr_o | (adr_i[i] & {ADDR_W{grant_i[i]}});
            dat_o = dat_o | (dat_i[i] & {DATA_W{grant_i[i]}});
            sel_o = sel_o | (sel_i[i] & {SEL_W{grant_i[i]}});
        end
    end

endmodule

// File: rtl/arb_resp_route.sv
module arb_resp_route
    import arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_MASTERS-1:0]             grant_i,
    input  logic                               ack_i,
    input  logic [DATA_W-1:0]                  dat_i,
    output logic [NUM_MASTERS-1:0]             ack_o,
    output logic [NUM_MASTERS-1:0][DATA_W-1:0] dat_o
);

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_route
        assign ack_o[g] = ack_i & grant_i[g];
        assign dat_o[g] = dat_i & {DATA_W{grant_i[g]}};
    end

endmodule

// File: rtl/bus_arb2.sv
module bus_arb2
    import arb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int SEL_W = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              m0_cyc_i,
    input  logic              m0_stb_i,
    input  logic              m0_we_i,
    input  logic [ADDR_W-1:0] m0_adr_i,
    input  logic [DATA_W-1:0] m0_dat_w_i,
    input  logic [SEL_W-1:0]  m0_sel_i,
    output logic              m0_ack_o,
    output logic [DATA_W-1:0] m0_dat_r_o,
    input  logic              m1_cyc_i,
    input  logic              m1_stb_i,
    input  logic              m1_we_i,
    input  logic [ADDR_W-1:0] m1_adr_i,
    input  logic [DATA_W-1:0] m1_dat_w_i,
    input  logic [SEL_W-1:0]  m1_sel_i,
    output logic              m1_ack_o,
    output logic [DATA_W-1:0] m1_dat_r_o,
    output logic              bus_cyc_o,
    output logic              bus_stb_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_adr_o,
    output logic [DATA_W-1:0] bus_dat_w_o,
    output logic [SEL_W-1:0]  bus_sel_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_dat_r_i
);

    logic [NUM_MASTERS-1:0]             grant;
    logic [NUM_MASTERS-1:0]             cyc_v, stb_v, we_v, ack_v;
    logic [NUM_MASTERS-1:0][ADDR_W-1:0] adr_v;
    logic [NUM_MASTERS-1:0][DATA_W-1:0] datw_v, datr_v;
    logic [NUM_MASTERS-1:0][SEL_W-1:0]  sel_v;

    assign cyc_v  = {m1_cyc_i, m0_cyc_i};
    assign stb_v  = {m1_stb_i, m0_stb_i};
    assign we_v   = {m1_we_i,  m0_we_i};
    assign adr_v  = {m1_adr_i, m0_adr_i};
    assign datw_v = {m1_dat_w_i, m0_dat_w_i};
    assign sel_v  = {m1_sel_i, m0_sel_i};

    arb_owner_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .req_i   (cyc_v),
        .grant_o (grant)
    );

    arb_req_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .grant_i (grant),
        .cyc_i   (cyc_v),
        .stb_i   (stb_v),
        .we_i    (we_v),
        .adr_i   (adr_v),
        .dat_i   (datw_v),
        .sel_i   (sel_v),
        .cyc_o   (bus_cyc_o),
        .stb_o   (bus_stb_o),
        .we_o    (bus_we_o),
        .adr_o   (bus_adr_o),
        .dat_o   (bus_dat_w_o),
        .sel_o   (bus_sel_o)
    );

    arb_resp_route #(.DATA_W(DATA_W)) u_route (
        .grant_i (grant),
        .ack_i   (bus_ack_i),
        .dat_i   (bus_dat_r_i),
        .ack_o   (ack_v),
        .dat_o   (datr_v)
    );

    assign m0_ack_o   = ack_v[0];
    assign m1_ack_o   = ack_v[1];
    assign m0_dat_r_o = datr_v[0];
    assign m1_dat_r_o = datr_v[1];

    // R8
    idle_bus_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant == 2'b00) |-> (!bus_cyc_o && !bus_stb_o && bus_adr_o == '0));

    // R7
    ack_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(m0_ack_o && m1_ack_o));

    // R8
    bus_cyc_owner_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_cyc_o |-> (grant[0] ? m0_cyc_i : m1_cyc_i));

endmodule

// File: tb/bus_arb2_tb_top.sv
`timescale 1ns/1ps
module bus_arb2_tb_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          m0_cyc, m0_stb, m0_we, m1_cyc, m1_stb, m1_we;
    logic [AW-1:0] m0_adr, m1_adr, bus_adr;
    logic [DW-1:0] m0_dw, m1_dw, m0_dr, m1_dr, bus_dw, bus_dr;
    logic [SW-1:0] m0_sel, m1_sel, bus_sel;
    logic          m0_ack, m1_ack, bus_cyc, bus_stb, bus_we, bus_ack;

    always #5 clk = ~clk;

    bus_arb2 #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .m0_cyc_i(m0_cyc), .m0_stb_i(m0_stb), .m0_we_i(m0_we),
        .m0_adr_i(m0_adr), .m0_dat_w_i(m0_dw), .m0_sel_i(m0_sel),
        .m0_ack_o(m0_ack), .m0_dat_r_o(m0_dr),
        .m1_cyc_i(m1_cyc), .m1_stb_i(m1_stb), .m1_we_i(m1_we),
        .m1_adr_i(m1_adr), .m1_dat_w_i(m1_dw), .m1_sel_i(m1_sel),
        .m1_ack_o(m1_ack), .m1_dat_r_o(m1_dr),
        .bus_cyc_o(bus_cyc), .bus_stb_o(bus_stb), .bus_we_o(bus_we),
        .bus_adr_o(bus_adr), .bus_dat_w_o(bus_dw), .bus_sel_o(bus_sel),
        .bus_ack_i(bus_ack), .bus_dat_r_i(bus_dr)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    int    owner  = 0;   // 0 none, 1 master 0, 2 master 1
    int    last   = 1;   // index of most recent owner
    string tag    = "R1";
    int    cycles = 0;
    bit    done   = 0;

    // behavioural reference of ownership
    always @(posedge clk) begin
        if (rst) begin
            owner = 0; last = 1; tag = "R1";
        end else begin
            if (owner == 0) begin
                if (m0_cyc && m1_cyc) begin owner = (last == 1) ? 1 : 2; tag = "R3"; end
                else if (m0_cyc) begin owner = 1; tag = "R2"; end
                else if (m1_cyc) begin owner = 2; tag = "R2"; end
            end else begin
                bit own_c, oth_c;
                own_c = (owner == 1) ? m0_cyc : m1_cyc;
                oth_c = (owner == 1) ? m1_cyc : m0_cyc;
                if (own_c) begin
                    if (oth_c) tag = "R4";
                end else if (oth_c) begin
                    owner = 3 - owner; tag = "R5";
                end else begin
                    owner = 0; tag = "R6";
                end
            end
            if (owner != 0) last = owner - 1;
        end
    end

    task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [AW-1:0] e_adr; logic [DW-1:0] e_dw; logic [SW-1:0] e_sel;
        logic e_cyc, e_stb, e_we;
        e_cyc = 0; e_stb = 0; e_we = 0; e_adr = '0; e_dw = '0; e_sel = '0;
        if (owner == 1) begin
            e_cyc = m0_cyc; e_stb = m0_stb; e_we = m0_we; e_adr = m0_adr; e_dw = m0_dw; e_sel = m0_sel;
        end else if (owner == 2) begin
            e_cyc = m1_cyc; e_stb = m1_stb; e_we = m1_we; e_adr = m1_adr; e_dw = m1_dw; e_sel = m1_sel;
        end
        // owner-dependent bus fields carry the tag of the last ownership event; R8 forwarding
        chk(tag, "bus_adr (R8)", 64'(bus_adr), 64'(e_adr));
        chk(tag, "bus_cyc (R8)", 64'(bus_cyc), 64'(e_cyc));
        chk("R8", "bus_stb", 64'(bus_stb), 64'(e_stb));
        chk("R8", "bus_we", 64'(bus_we), 64'(e_we));
        chk("R8", "bus_dat_w", 64'(bus_dw), 64'(e_dw));
        chk("R8", "bus_sel", 64'(bus_sel), 64'(e_sel));
        chk("R7", "m0_ack", 64'(m0_ack), 64'(bus_ack && owner == 1));
        chk("R7", "m1_ack", 64'(m1_ack), 64'(bus_ack && owner == 2));
        chk("R7", "m0_dat_r", 64'(m0_dr), 64'((owner == 1) ? bus_dr : '0));
        chk("R7", "m1_dat_r", 64'(m1_dr), 64'((owner == 2) ? bus_dr : '0));
    endtask

    task automatic step(bit c0, bit c1, bit ack);
        @(negedge clk);
        m0_cyc = c0; m0_stb = c0; m0_we = $urandom_range(0, 1);
        m1_cyc = c1; m1_stb = c1; m1_we = $urandom_range(0, 1);
        m0_adr = {8'hA0, 24'($urandom)}; m1_adr = {8'hB1, 24'($urandom)};
        m0_dw = $urandom; m1_dw = $urandom;
        m0_sel = SW'($urandom); m1_sel = SW'($urandom);
        bus_ack = ack; bus_dr = $urandom;
        #1;
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        bit c0, c1;
        rst = 1'b1;
        m0_cyc = 0; m0_stb = 0; m0_we = 0; m0_adr = '0; m0_dw = '0; m0_sel = '0;
        m1_cyc = 0; m1_stb = 0; m1_we = 0; m1_adr = '0; m1_dw = '0; m1_sel = '0;
        bus_ack = 0; bus_dr = '0;
        // R1: reset and quiet period, with ack active to show no leakage
        step(1, 1, 1); step(1, 0, 1); step(0, 1, 1);
        @(negedge clk); rst = 1'b0;
        step(0, 0, 1); step(0, 0, 1);
        // R2 master 0 alone, R4 hold while master 1 waits
        step(1, 0, 1); step(1, 1, 1); step(1, 1, 0); step(1, 1, 1);
        // R5 handover to master 1, R6 release
        step(0, 1, 1); step(0, 1, 1); step(0, 0, 1); step(0, 0, 0);
        // R3 tie: last owner is master 1, so master 0 wins
        step(1, 1, 1); step(1, 1, 1);
        // R5 back to master 1, then R3 tie with last owner master 1 after release
        step(0, 1, 1); step(0, 1, 1); step(0, 0, 0);
        step(1, 1, 1); step(1, 1, 1); step(0, 0, 1); step(0, 0, 1);
        // R2 master 1 alone, then tie: last owner master 1 -> master 0
        step(0, 1, 1); step(0, 0, 1); step(1, 1, 1); step(1, 1, 1); step(0, 0, 1);
        // random bursts
        c0 = 0; c1 = 0;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) c0 = ~c0;
            if ($urandom_range(0, 3) == 0) c1 = ~c1;
            step(c0, c1, 1'($urandom));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule